// File: doc/BRIEF.md
# Serial Display Register Access Engine

This block is a serial-bus master that performs register transactions with a small display controller. A local requester asks for one of four operations: set the index, write a 16-bit register, read a 16-bit register, or read the status word. The engine then builds the framed byte sequence and drives the serial clock, data-out and chip-select lines. It samples the data-in line and, when the transaction ends, returns the 16-bit result together with a one-cycle done pulse.

Every frame opens with a composite header byte. This byte carries a one-bit device identifier, a bit that selects between the index register and register data, and a direction bit. Register accesses take two frames: the index is set first, then the value moves in a separate chip-select frame. A status read is a single longer frame, and the first byte returned after the header is thrown away. A configuration input can complement every transmitted byte.

The serial clock half-period is a parameter counted in system clocks. The default keeps the bus at or below 4 MHz when the system clock is 200 MHz.

Top module: `dspi_reg_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, done is 0 and rdata is 0. While busy is 0, cs_n stays 1.
- R2: The header byte is 0x70 | id<<2 | sel<<1 | dir, where sel=0 targets the index register, sel=1 targets register data, dir=0 writes and dir=1 reads. Bytes are shifted MSB first in SPI mode 0: sclk idles low, mosi changes only while sclk is low, and miso is sampled on the rising edge.
- R3: req_op=0 (index set) sends one frame of three bytes: header(sel=0, dir=0), 0x00, req_index.
- R4: req_op=1 (register write) sends the R3 frame, then a second frame: header(sel=1, dir=0), req_wdata[15:8], req_wdata[7:0].
- R5: req_op=2 (register read) sends the R3 frame, then a second frame: header(sel=1, dir=1), 0x00, 0x00. The result is the second received byte of that frame in rdata[15:8] and the third in rdata[7:0].
- R6: req_op=3 (status read) sends one frame of four bytes: header(sel=0, dir=1) followed by three 0x00 bytes. The second received byte is discarded, the third goes to rdata[15:8] and the fourth to rdata[7:0].
- R7: When cfg_invert is 1 at request time, every transmitted byte is complemented, so filler bytes go out as 0xFF. Received bytes are not affected.
- R8: sclk stays high for exactly HALF_DIV clock cycles per bit. sclk is 0 whenever cs_n is 1. Between frames, cs_n stays high for at least 2*HALF_DIV cycles.
- R9: busy rises in the cycle after a request is accepted. done is a single-cycle pulse that appears in the first cycle after busy falls.
- R10: A request made while busy is 1 is ignored: it produces no frame and no done.
- R11: rdata changes only at the done of an op 2 or op 3 transaction. Index-set and write operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when busy is 0 |
| req_op | input | 2 | 0 index set, 1 write, 2 read, 3 status |
| req_index | input | 8 | Register number |
| req_wdata | input | 16 | Value for a register write |
| cfg_dev_id | input | 1 | Device identifier bit placed in the header |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| miso | input | 1 | Serial data from the controller |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read or status operation |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the controller |
| cs_n | output | 1 | Active-low chip select |

## Verification
If the sequencer counts bytes wrongly, a frame has the wrong length, and this shows at the next rise of cs_n, within one frame time. A wrong header field or a wrong inversion setting corrupts the first byte, which is visible eight serial clocks after cs_n falls. A result taken from the wrong byte slot, for example the discarded status byte, shows up in rdata at the done pulse. Faults in the state sequencing break the done and busy timing, or let a request that arrives while busy produce an extra frame.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    typedef enum logic [1:0] {
        OP_INDEX  = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_STATUS = 2'd3
    } dspi_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ISSUE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } dspi_state_e;

    typedef struct packed {
        dspi_op_e    op;
        logic [7:0]  idx;
        logic [15:0] wd;
        logic        id;
        logic        inv;
    } dspi_req_t;

    localparam logic [4:0] HDR_LEAD = 5'b01110;

    function automatic logic [7:0] hdr_byte(input logic id, input logic sel, input logic dir);
        return {HDR_LEAD, id, sel, dir};
    endfunction

    function automatic logic two_frames(input dspi_op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    function automatic logic [1:0] last_slot(input dspi_op_e op, input logic frame);
        return (!frame && op == OP_STATUS) ? 2'd3 : 2'd2;
    endfunction

    // Byte to transmit in a given slot of a given frame, before inversion.
    function automatic logic [7:0] slot_byte(input dspi_req_t r, input logic frame,
                                             input logic [1:0] slot);
        logic [7:0] b;
        b = 8'h00;
        if (!frame) begin
            if (slot == 2'd0)
                b = hdr_byte(r.id, 1'b0, r.op == OP_STATUS);
            else if (slot == 2'd2 && r.op != OP_STATUS)
                b = r.idx;
        end else begin
            if (slot == 2'd0)
                b = hdr_byte(r.id, 1'b1, r.op == OP_READ);
            else if (r.op == OP_WRITE)
                b = (slot == 2'd1) ? r.wd[15:8] : r.wd[7:0];
        end
        return b;
    endfunction

endpackage

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
    parameter int HALF_DIV = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] HALF_END = CW'(HALF_DIV - 1);

    logic          active;
    logic          phase_hi;
    logic [2:0]    bit_idx;
    logic [CW-1:0] tmr;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            phase_hi  <= 1'b0;
            bit_idx   <= '0;
            tmr       <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    tx_sr    <= tx_byte;
                    bit_idx  <= '0;
                    phase_hi <= 1'b0;
                    tmr      <= '0;
                end
            end else if (tmr == HALF_END) begin
                tmr <= '0;
                if (!phase_hi) begin
                    phase_hi <= 1'b1;
                    rx_sr    <= {rx_sr[6:0], miso};
                end else begin
                    phase_hi <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        tx_sr   <= {tx_sr[6:0], 1'b0};
                    end
                end
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    assign sclk    = phase_hi;
    assign mosi    = active & tx_sr[7];
    assign rx_byte = rx_sr;

endmodule

// File: rtl/dspi_sequencer.sv
module dspi_sequencer
    import dspi_pkg::*;
#(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  dspi_req_t   req,
    input  logic        byte_done,
    input  logic [7:0]  rx_byte,
    output logic        sh_start,
    output logic [7:0]  sh_tx,
    output logic        cs_n,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int TW = $clog2(2 * HALF_DIV + 1);
    localparam logic [TW-1:0] EDGE_END = TW'(HALF_DIV - 1);
    localparam logic [TW-1:0] GAP_END  = TW'(2 * HALF_DIV - 1);

    dspi_state_e   state;
    dspi_req_t     cur;
    logic          frame;
    logic [1:0]    slot;
    logic [TW-1:0] tmr;
    logic [15:0]   res;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            frame <= 1'b0;
            slot  <= '0;
            tmr   <= '0;
            res   <= '0;
            rdata <= '0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur   <= req;
                        frame <= 1'b0;
                        slot  <= '0;
                        tmr   <= '0;
                        cs_n  <= 1'b0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tmr == EDGE_END) begin
                        tmr   <= '0;
                        state <= ST_ISSUE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_ISSUE: state <= ST_SHIFT;
                ST_SHIFT: begin
                    if (byte_done) begin
                        if (frame && cur.op == OP_READ) begin
                            if (slot == 2'd1) res[15:8] <= rx_byte;
                            if (slot == 2'd2) res[7:0]  <= rx_byte;
                        end
                        if (!frame && cur.op == OP_STATUS) begin
                            if (slot == 2'd2) res[15:8] <= rx_byte;
                            if (slot == 2'd3) res[7:0]  <= rx_byte;
                        end
                        if (slot == last_slot(cur.op, frame)) begin
                            tmr   <= '0;
                            state <= ST_HOLD;
                        end else begin
                            slot  <= slot + 2'd1;
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tmr == EDGE_END) begin
                        tmr   <= '0;
                        cs_n  <= 1'b1;
                        state <= ST_GAP;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tmr == GAP_END) begin
                        tmr <= '0;
                        if (!frame && two_frames(cur.op)) begin
                            frame <= 1'b1;
                            slot  <= '0;
                            cs_n  <= 1'b0;
                            state <= ST_SETUP;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                            if (cur.op == OP_READ || cur.op == OP_STATUS)
                                rdata <= res;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign sh_start = (state == ST_ISSUE);
    assign sh_tx    = slot_byte(cur, frame, slot) ^ {8{cur.inv}};

endmodule

// File: rtl/dspi_reg_master.sv
module dspi_reg_master
    import dspi_pkg::*;
#(
    parameter int HALF_DIV = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    input  logic        cfg_dev_id,
    input  logic        cfg_invert,
    input  logic        miso,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n
);
    dspi_req_t  req;
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       byte_done;
    logic [7:0] rx_byte;

    always_comb begin
        req.op  = dspi_op_e'(req_op);
        req.idx = req_index;
        req.wd  = req_wdata;
        req.id  = cfg_dev_id;
        req.inv = cfg_invert;
    end

    dspi_sequencer #(.HALF_DIV(HALF_DIV)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata)
    );

    dspi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

endmodule

// File: rtl/dspi_reg_master_chk.sv
module dspi_reg_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        sclk,
    input logic        mosi,
    input logic        cs_n
);
    a_r8_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r9_done_after_busy_falls: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    a_r11_rdata_only_at_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rdata));

endmodule

bind dspi_reg_master dspi_reg_master_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy),
    .done  (done),
    .rdata (rdata),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
);

// File: tb/sim_dspi_reg_master.sv
module sim_dspi_reg_master;
    localparam int HALF = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_index = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        cfg_dev_id = 1'b0;
    logic        cfg_invert = 1'b0;
    logic        miso = 1'b0;
    logic        busy, done, sclk, mosi, cs_n;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    dspi_reg_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_wdata(req_wdata), .cfg_dev_id(cfg_dev_id),
        .cfg_invert(cfg_invert), .miso(miso), .busy(busy), .done(done),
        .rdata(rdata), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] exp_fd[$];
    int          exp_fl[$];
    string       exp_ft[$];
    logic [15:0] exp_rv[$];
    string       exp_rt[$];
    logic [15:0] rd_model = 16'h0000;
    logic [31:0] rsp_word = 32'h0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [7:0] hb(input logic id, input logic sel, input logic dir);
        return 8'h70 | ({7'd0, id} << 2) | ({7'd0, sel} << 1) | {7'd0, dir};
    endfunction

    // Serial-side monitor and responder, sampled at the falling clock edge.
    int          cyc = 0;
    logic        p_sclk = 1'b0;
    logic        p_cs = 1'b1;
    int          rise_cyc = -1000;
    int          hi_start = 0;
    int          fbits = 0;
    int          flen = 0;
    int          mbit = 0;
    logic [7:0]  cur_b = 8'h0;
    logic [31:0] fdata = 32'h0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (p_cs && !cs_n) begin
                check(cyc - rise_cyc >= 2 * HALF, "R8 cs gap", cyc - rise_cyc, 2 * HALF);
                fbits = 0; flen = 0; fdata = 0; mbit = 0;
                miso = rsp_word[31];
            end
            if (!cs_n) begin
                if (!p_sclk && sclk) begin
                    cur_b = {cur_b[6:0], mosi};
                    fbits++;
                    hi_start = cyc;
                    if (fbits == 8) begin
                        fdata = {fdata[23:0], cur_b};
                        flen++;
                        fbits = 0;
                    end
                end
                if (p_sclk && !sclk) begin
                    check(cyc - hi_start == HALF, "R8 sclk high time", cyc - hi_start, HALF);
                    mbit++;
                    if (mbit < 32) miso = rsp_word[31 - mbit];
                end
            end
            if (!p_cs && cs_n) begin
                rise_cyc = cyc;
                if (exp_fd.size() == 0) begin
                    check(0, "R10 unexpected frame", fdata, 0);
                end else begin
                    logic [31:0] ed;
                    int el;
                    string et;
                    ed = exp_fd.pop_front();
                    el = exp_fl.pop_front();
                    et = exp_ft.pop_front();
                    check(fdata == ed && flen == el && fbits == 0, et, fdata, ed);
                end
            end
            if (cs_n && sclk) check(0, "R8 sclk high while deselected", 1, 0);
            if (done) begin
                check(!busy, "R9 busy low at done", busy, 0);
                if (exp_rv.size() == 0) begin
                    check(0, "R10 unexpected done", rdata, 0);
                end else begin
                    logic [15:0] ev;
                    string rt;
                    ev = exp_rv.pop_front();
                    rt = exp_rt.pop_front();
                    check(rdata == ev, rt, rdata, ev);
                end
            end
        end
        p_sclk = sclk;
        p_cs = cs_n;
    end

    task automatic run_op(input logic [1:0] op, input logic [7:0] idx, input logic [15:0] wd,
                          input logic id, input logic inv, input logic [31:0] rsp,
                          input string tag, input bit intrude);
        logic [7:0] m;
        m = inv ? 8'hFF : 8'h00;
        if (op == 2'd3) begin
            exp_fd.push_back({hb(id, 1'b0, 1'b1) ^ m, m, m, m});
            exp_fl.push_back(4);
        end else begin
            exp_fd.push_back({8'h00, hb(id, 1'b0, 1'b0) ^ m, m, idx ^ m});
            exp_fl.push_back(3);
        end
        exp_ft.push_back({tag, " frame 1"});
        if (op == 2'd1) begin
            exp_fd.push_back({8'h00, hb(id, 1'b1, 1'b0) ^ m, wd[15:8] ^ m, wd[7:0] ^ m});
            exp_fl.push_back(3);
            exp_ft.push_back({tag, " frame 2"});
        end
        if (op == 2'd2) begin
            exp_fd.push_back({8'h00, hb(id, 1'b1, 1'b1) ^ m, m, m});
            exp_fl.push_back(3);
            exp_ft.push_back({tag, " frame 2"});
        end
        if (op == 2'd2) rd_model = rsp[23:8];
        if (op == 2'd3) rd_model = rsp[15:0];
        exp_rv.push_back(rd_model);
        exp_rt.push_back({tag, " rdata (R11)"});

        @(negedge clk);
        while (busy) @(negedge clk);
        rsp_word = rsp;
        cfg_dev_id = id; cfg_invert = inv;
        req_op = op; req_index = idx; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R9 busy after request", busy, 1);
        if (intrude) begin
            repeat (100) @(negedge clk);
            req_op = 2'd3; req_index = 8'h5A; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
              "R1 reset outputs", {cs_n, sclk, busy, done}, 4'b1000);
        check(rdata == 16'h0, "R1 reset rdata", rdata, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2'b10);

        run_op(2'd0, 8'h22, 16'h0000, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3 R2 index set", 0);
        run_op(2'd1, 8'h10, 16'h4240, 1'b1, 1'b0, 32'h0, "R4 register write", 0);
        run_op(2'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 32'hA592_2100, "R5 register read", 0);
        run_op(2'd3, 8'h00, 16'h0000, 1'b0, 1'b0, 32'h1122_C35A, "R6 status read", 0);
        run_op(2'd1, 8'h05, 16'h1234, 1'b1, 1'b0, 32'h0, "R11 write keeps rdata", 0);
        run_op(2'd1, 8'h05, 16'h1234, 1'b1, 1'b1, 32'h0, "R7 inverted write", 0);
        run_op(2'd2, 8'h3C, 16'h0000, 1'b0, 1'b1, 32'h00BE_EF00, "R7 inverted read", 0);
        run_op(2'd3, 8'h00, 16'h0000, 1'b1, 1'b1, 32'h7777_6C81, "R7 inverted status", 0);
        run_op(2'd0, 8'hE1, 16'h0000, 1'b0, 1'b0, 32'h0, "R10 index set with intrusion", 1);
        run_op(2'd2, 8'h45, 16'h0000, 1'b1, 1'b0, 32'h5500_FF00, "R10 read with intrusion", 1);
        run_op(2'd0, 8'h00, 16'h0000, 1'b1, 1'b1, 32'h0, "R3 index zero inverted", 0);

        repeat (400) @(negedge clk);
        check(exp_fd.size() == 0, "R10 all frames seen", exp_fd.size(), 0);
        check(exp_rv.size() == 0, "R9 all done pulses seen", exp_rv.size(), 0);
        check(cs_n == 1'b1 && busy == 1'b0, "R1 idle at end", {cs_n, busy}, 2'b10);
        finish_run();
    end

endmodule